// File: doc/BRIEF.md
# No-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable synchronous static memory model whose bus never idles when traffic flips between reads and writes. Every command is captured on a rising clock edge: chip selects, direction, burst advance, address and per-byte write strobes. A write takes its data two edges after its command. A read lands in an output register one edge after its command. Both therefore occupy the same bus slot, and any read/write mix runs at one command per clock.

The array holds 256 words of 36 bits, split into four 9-bit bytes. A burst-advance input walks the two low address bits through a four-beat sequence. A static mode pin picks whether that sequence is linear or interleaved. Output enable and sleep act asynchronously on the output drive. Sleep also blocks new commands. A read that hits a write whose data arrives on the same edge returns the merged new word.

Top module: `nbt_sram`

## Requirements
- R1: A command is accepted only when all three bits of `cs_i` are 1 and `sleep_i` is 0; any other select value writes nothing and produces no read drive.
- R2: A write accepted at edge N stores `wdata_i` sampled at edge N+2, updating only byte k (bits 9k+8..9k) where `bw_i[k]` was 1 at edge N.
- R3: A read accepted at edge N presents the addressed word on `rdata_o` with `rdrive_o` = 1 from edge N+1 until edge N+2.
- R4: Reads and writes may alternate on consecutive edges with no idle cycle, and every read returns the word written by all earlier-issued writes.
- R5: A read issued one edge after a write to the same address returns the merged word of that write.
- R6: With `burst_ilv_i` = 0, the k-th advance after a command at base address B uses low bits (B[1:0] + k) mod 4.
- R7: With `burst_ilv_i` = 1, the k-th advance uses low bits B[1:0] XOR (k mod 4).
- R8: An advance (`adv_i` = 1) ignores `addr_i` and `we_i`, keeps the base upper address bits and the direction of the last non-advance command, wraps after four beats, and uses the current `bw_i`.
- R9: When `oe_i` is 0, `rdrive_o` and `rdata_o` are 0 at once, without waiting for a clock edge.
- R10: While `sleep_i` is 1, `rdrive_o` and `rdata_o` are 0 and commands are not accepted.
- R11: While and after reset, with no read issued, `rdrive_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_i | input | 3 | Chip selects, all high to select |
| we_i | input | 1 | 1 = write, 0 = read |
| adv_i | input | 1 | Burst advance |
| addr_i | input | 8 | Word address |
| bw_i | input | 4 | Byte write enables, bit k for byte k |
| wdata_i | input | 36 | Write data, two edges after its command |
| burst_ilv_i | input | 1 | Static burst order: 0 linear, 1 interleaved |
| oe_i | input | 1 | Asynchronous output enable |
| sleep_i | input | 1 | Asynchronous sleep |
| rdata_o | output | 36 | Read data, 0 when not driven |
| rdrive_o | output | 1 | Read data valid and driven |

## Verification
A full sweep writes and then reads every address, which separates address decoding from data-path faults. All sixteen byte-strobe patterns are applied to partial writes over known words, which exposes faulty byte lanes. Strictly alternating read/write traffic, plus reads issued one and two edges after a write to the same word, separate correct late-write timing and forwarding from stale reads. Bursts from each of the four start offsets in both order modes, including a fifth beat that wraps, are checked against the arithmetic sequence, and select, output-enable and sleep patterns confirm that nothing is written or driven when it must not be.

// File: rtl/nbt_pkg.sv
`timescale 1ns/1ps
package nbt_pkg;
  typedef enum logic {BURST_LIN = 1'b0, BURST_ILV = 1'b1} burst_mode_e;

  function automatic logic [1:0] burst_ofs(input logic [1:0] base, input logic [1:0] beat,
                                           input burst_mode_e mode);
    return (mode == BURST_ILV) ? (base ^ beat) : (base + beat);
  endfunction
endpackage

// File: rtl/nbt_burst_gen.sv
`timescale 1ns/1ps
module nbt_burst_gen #(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_i,
  input  logic          adv_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic          ilv_i,
  output logic [AW-1:0] addr_o,
  output logic          we_o
);
  import nbt_pkg::*;

  logic [AW-1:0] base_q;
  logic          we_q;
  logic [1:0]    beat_q, beat_nxt;
  burst_mode_e   mode;

  assign mode     = burst_mode_e'(ilv_i);
  assign beat_nxt = beat_q + 2'd1;
  assign addr_o   = adv_i ? {base_q[AW-1:2], burst_ofs(base_q[1:0], beat_nxt, mode)} : addr_i;
  assign we_o     = adv_i ? we_q : we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      we_q   <= 1'b0;
      beat_q <= '0;
    end else if (acc_i) begin
      if (adv_i) begin
        beat_q <= beat_nxt;
      end else begin
        base_q <= addr_i;
        we_q   <= we_i;
        beat_q <= '0;
      end
    end
  end

  // R6 R7
  burst_ofs_moves_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && adv_i && beat_nxt != 2'd0) |-> (addr_o[1:0] != base_q[1:0]));
  // R8
  burst_resets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !adv_i) |=> (beat_q == 2'd0 && base_q == $past(addr_i)));
endmodule

// File: rtl/nbt_cmd_pipe.sv
`timescale 1ns/1ps
module nbt_cmd_pipe #(
  parameter int unsigned AW = 8,
  parameter int unsigned NB = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          v_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [NB-1:0] be_i,
  output logic [STAGES-1:0]         v_o,
  output logic [STAGES-1:0]         we_o,
  output logic [STAGES-1:0][AW-1:0] addr_o,
  output logic [STAGES-1:0][NB-1:0] be_o
);
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic          v_d, we_d;
    logic [AW-1:0] a_d;
    logic [NB-1:0] b_d;
    if (s == 0) begin : g_head
      assign v_d = v_i;  assign we_d = we_i; assign a_d = addr_i; assign b_d = be_i;
    end else begin : g_tail
      assign v_d = v_o[s-1]; assign we_d = we_o[s-1];
      assign a_d = addr_o[s-1]; assign b_d = be_o[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_o[s] <= 1'b0; we_o[s] <= 1'b0; addr_o[s] <= '0; be_o[s] <= '0;
      end else begin
        v_o[s] <= v_d; we_o[s] <= we_d; addr_o[s] <= a_d; be_o[s] <= b_d;
      end
    end
  end
endmodule

// File: rtl/nbt_array.sv
`timescale 1ns/1ps
module nbt_array #(
  parameter int unsigned AW = 8,
  parameter int unsigned NB = 4,
  parameter int unsigned BW = 9,
  localparam int unsigned DW = NB * BW,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          wr_v_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [NB-1:0] wr_be_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] raw;
  logic          hit;

  assign raw = mem_q[rd_addr_i];
  assign hit = wr_v_i && (wr_addr_i == rd_addr_i);

  for (genvar b = 0; b < NB; b++) begin : g_byte
    // forward the byte whose data lands on this edge
    assign rd_data_o[b*BW +: BW] = (hit && wr_be_i[b]) ? wdata_i[b*BW +: BW] : raw[b*BW +: BW];
    always_ff @(posedge clk_i) begin
      if (wr_v_i && wr_be_i[b]) mem_q[wr_addr_i][b*BW +: BW] <= wdata_i[b*BW +: BW];
    end
  end
endmodule

// File: rtl/nbt_out.sv
`timescale 1ns/1ps
module nbt_out #(
  parameter int unsigned DW = 36
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic          oe_i,
  input  logic          sleep_i,
  output logic [DW-1:0] rdata_o,
  output logic          rdrive_o
);
  logic          rvalid_q;
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= load_i;
      if (load_i) rdata_q <= data_i;
    end
  end

  assign rdrive_o = rvalid_q && oe_i && !sleep_i;
  assign rdata_o  = rdrive_o ? rdata_q : '0;

  // R3
  drive_has_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdrive_o |-> $past(load_i));
endmodule

// File: rtl/nbt_sram.sv
`timescale 1ns/1ps
module nbt_sram #(
  parameter int unsigned AW = 8,
  parameter int unsigned NB = 4,
  parameter int unsigned BW = 9,
  parameter int unsigned NCS = 3,
  localparam int unsigned DW = NB * BW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCS-1:0] cs_i,
  input  logic           we_i,
  input  logic           adv_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [NB-1:0]  bw_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic           burst_ilv_i,
  input  logic           oe_i,
  input  logic           sleep_i,
  output logic [DW-1:0]  rdata_o,
  output logic           rdrive_o
);
  logic          acc, eff_we;
  logic [AW-1:0] eff_addr;
  logic [1:0]          p_v, p_we;
  logic [1:0][AW-1:0]  p_addr;
  logic [1:0][NB-1:0]  p_be;
  logic          wr_v;
  logic [DW-1:0] rd_word;

  assign acc = (&cs_i) && !sleep_i;

  nbt_burst_gen #(.AW(AW)) i_burst (
    .clk_i, .rst_ni, .acc_i(acc), .adv_i, .we_i, .addr_i,
    .ilv_i(burst_ilv_i), .addr_o(eff_addr), .we_o(eff_we)
  );

  nbt_cmd_pipe #(.AW(AW), .NB(NB), .STAGES(2)) i_pipe (
    .clk_i, .rst_ni, .v_i(acc), .we_i(eff_we), .addr_i(eff_addr), .be_i(bw_i),
    .v_o(p_v), .we_o(p_we), .addr_o(p_addr), .be_o(p_be)
  );

  assign wr_v = p_v[1] && p_we[1];

  nbt_array #(.AW(AW), .NB(NB), .BW(BW)) i_array (
    .clk_i, .wr_v_i(wr_v), .wr_addr_i(p_addr[1]), .wr_be_i(p_be[1]),
    .wdata_i, .rd_addr_i(p_addr[0]), .rd_data_o(rd_word)
  );

  nbt_out #(.DW(DW)) i_out (
    .clk_i, .rst_ni, .load_i(p_v[0] && !p_we[0]), .data_i(rd_word),
    .oe_i, .sleep_i, .rdata_o, .rdrive_o
  );

  // R1
  desel_no_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&cs_i) |=> !p_v[0]);
  // R10
  sleep_no_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> !p_v[0]);
  // R2
  late_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(acc && eff_we && rst_ni, 2) && $past(rst_ni, 1) |-> wr_v);
endmodule

// File: tb/test_nbt_sram.sv
`timescale 1ns/1ps
module test_nbt_sram;
  localparam int AW = 8, NB = 4, BW = 9, DW = 36;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_ni, we_i, adv_i, burst_ilv_i, oe_i, sleep_i, rdrive_o;
  logic [2:0] cs_i;
  logic [AW-1:0] addr_i;
  logic [NB-1:0] bw_i;
  logic [DW-1:0] wdata_i, rdata_o;

  nbt_sram i_nbt_sram (
    .clk_i(clk), .rst_ni, .cs_i, .we_i, .adv_i, .addr_i, .bw_i, .wdata_i,
    .burst_ilv_i, .oe_i, .sleep_i, .rdata_o, .rdrive_o
  );

  int n_chk = 0, n_fail = 0;
  string req = "R11";

  logic [DW-1:0] ref_mem [256];
  logic          w1_v = 0, w2_v = 0, r1_v = 0, exp_v = 0;
  logic [7:0]    w1_a, w2_a, r1_a, base_a = 0;
  logic [3:0]    w1_b, w2_b;
  logic [DW-1:0] exp_d = '0;
  logic          b_we = 0;
  int            beat = 0, seq = 0;

  function automatic logic [DW-1:0] pat(input logic [7:0] a, input int s);
    return 36'(a) * 36'h1_0203_0405 ^ 36'(s) * 36'h0_9E37_79B9 ^ 36'h5_A5A5_A5A5;
  endfunction

  task automatic chk(input string r, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic check_out();
    logic drv;
    drv = exp_v && oe_i && !sleep_i;
    chk({req, " drive"}, 36'(rdrive_o), 36'(drv));
    chk({req, " data"}, rdata_o, drv ? exp_d : '0);
  endtask

  task automatic step(input logic [2:0] cs, input logic we, input logic adv,
                      input logic [7:0] a, input logic [3:0] be);
    logic acc, ew;
    logic [7:0] ea;
    logic [1:0] k;
    @(negedge clk);
    check_out();
    cs_i = cs; we_i = we; adv_i = adv; addr_i = a; bw_i = be;
    wdata_i = w2_v ? pat(w2_a, seq) : 36'h0;
    @(posedge clk); #1;
    if (w2_v) begin
      for (int b = 0; b < NB; b++)
        if (w2_b[b]) ref_mem[w2_a][b*BW +: BW] = wdata_i[b*BW +: BW];
      seq++;
    end
    exp_v = r1_v;
    if (r1_v) exp_d = ref_mem[r1_a];
    acc = (cs == 3'b111) && !sleep_i;
    ea = a; ew = we;
    if (acc) begin
      if (adv) begin
        beat = (beat + 1) % 4;
        k = 2'(beat);
        ea = {base_a[7:2], burst_ilv_i ? (base_a[1:0] ^ k) : (base_a[1:0] + k)};
        ew = b_we;
      end else begin
        base_a = a; b_we = we; beat = 0;
      end
    end
    w2_v = w1_v; w2_a = w1_a; w2_b = w1_b;
    w1_v = acc && ew; w1_a = ea; w1_b = be;
    r1_v = acc && !ew; r1_a = ea;
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] be); step(3'b111, 1, 0, a, be); endtask
  task automatic rd(input logic [7:0] a); step(3'b111, 0, 0, a, 4'h0); endtask
  task automatic nop(); step(3'b000, 0, 0, 8'h0, 4'h0); endtask
  task automatic advc(input logic [3:0] be); step(3'b111, 0, 1, 8'hFF, be); endtask

  initial begin
    #1000000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_ni = 0; cs_i = 0; we_i = 0; adv_i = 0; addr_i = 0; bw_i = 0; wdata_i = 0;
    burst_ilv_i = 0; oe_i = 1; sleep_i = 0;
    #12;
    chk("R11 reset drive", 36'(rdrive_o), 36'h0);
    @(negedge clk); rst_ni = 1;
    nop(); nop();

    req = "R2";
    for (int a = 0; a < 256; a++) wr(8'(a), 4'hF);
    req = "R3";
    for (int a = 0; a < 256; a++) rd(8'(a));
    nop(); nop();

    req = "R2";
    for (int b = 0; b < 16; b++) wr(8'(16 + b), 4'(b));
    nop(); nop();
    for (int b = 0; b < 16; b++) rd(8'(16 + b));

    req = "R4";
    for (int i = 0; i < 64; i++) begin wr(8'(i), 4'hF); rd(8'(i + 128)); end
    for (int i = 0; i < 32; i++) begin rd(8'(i)); wr(8'(i + 64), 4'(i)); end
    nop(); nop();

    req = "R5";
    for (int i = 0; i < 16; i++) begin wr(8'(96 + i), 4'(i)); rd(8'(96 + i)); end
    for (int i = 0; i < 8; i++) begin wr(8'(112 + i), 4'h5); nop(); rd(8'(112 + i)); end
    nop(); nop();

    req = "R1";
    for (int c = 0; c < 7; c++) begin
      step(3'(c), 1, 0, 8'd200, 4'hF);
      nop(); nop();
      step(3'(c), 0, 0, 8'd200, 4'h0);
      nop();
      rd(8'd200);
    end
    nop(); nop();

    for (int m = 0; m < 2; m++) begin
      burst_ilv_i = m[0];
      req = m ? "R7" : "R6";
      for (int b = 0; b < 4; b++) begin
        wr(8'(8'h40 + 16 * m + b), 4'hF);
        for (int k = 0; k < 3; k++) advc(4'hF);
        nop(); nop();
        rd(8'(8'h40 + 16 * m + b));
        for (int k = 0; k < 4; k++) advc(4'h0);
        nop(); nop();
        for (int k = 0; k < 4; k++) rd(8'(8'h40 + 16 * m + 4 * (b == 3) + k));
      end
      req = "R8";
      wr(8'h7A, 4'hF); advc(4'h3); advc(4'hC); advc(4'hF); advc(4'h1);
      nop(); nop();
      for (int k = 0; k < 4; k++) rd(8'(8'h78 + k));
      nop(); nop();
    end
    burst_ilv_i = 0;

    req = "R9";
    rd(8'd5); nop();
    oe_i = 0; #0.5;
    chk("R9 oe low drive", 36'(rdrive_o), 36'h0);
    chk("R9 oe low data", rdata_o, 36'h0);
    oe_i = 1; #0.5;
    chk("R9 oe high data", rdata_o, ref_mem[5]);
    nop(); nop();

    req = "R10";
    rd(8'd6); nop();
    sleep_i = 1; #0.5;
    chk("R10 sleep drive", 36'(rdrive_o), 36'h0);
    wr(8'd7, 4'hF); rd(8'd8); nop(); nop();
    sleep_i = 0;
    nop(); nop();
    rd(8'd7); rd(8'd8); nop(); nop();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule